// File: doc/BRIEF.md
# Subroutine Return Stack with Shadow Register Restore

This block keeps the return addresses of a small 8-bit processor core. When the core executes a call, the block pushes the address of the following instruction word (the current program counter plus two) onto a hardware last-in/first-out stack and steers the program counter to the call target. When the decoder presents the return opcode, the block pops the top entry and loads it into the program counter in the next cycle. That next cycle is a dead slot in which any instruction or call presented to the block is discarded.

The block also holds one saved copy each of the working register, the status register and the bank select register. The copies are captured when the interrupt logic asserts a shadow-load strobe or when a call is flagged as a fast call. The lowest bit of the return opcode selects whether those copies are handed back during the return. When it is clear, the restore strobe stays low and the live registers keep their values. The stack is 31 entries deep. A push onto a full stack and a pop from an empty stack each set their own sticky flag.

Top module: `retstk_unit`

## Requirements
- R1: A return is recognised only when `instr_valid` is high and `instr_word` equals 16'h0012 (restore bit, bit 0, clear) or 16'h0013 (restore bit set). Any other word, or a valid return word with `instr_valid` low, causes no program counter load and leaves `depth` unchanged.
- R2: In the cycle after a return is accepted, `pc_load` is 1, `pc_next` equals the most recently pushed address, and `depth` is one lower.
- R3: In that same cycle, `restore_en` is 1 exactly when the accepted word had bit 0 set, and `w_out`, `status_out` and `bsr_out` then carry the saved copies. With bit 0 clear, `restore_en` stays 0.
- R4: `ret_slot` is 1 in the cycle after an accepted return. A return or call presented while `ret_slot` is 1 is discarded: in the next cycle `pc_load` is 0 and `depth` is unchanged.
- R5: An accepted `call_req` pushes `pc_in + 2`. In the next cycle `pc_load` is 1, `pc_next` equals `call_target`, and `depth` is one higher.
- R6: The saved copies take `w_in`, `status_in` and `bsr_in` at the clock edge where `shadow_load` is high, or where an accepted call has `call_fast` high. At any other edge they hold their values.
- R7: A call accepted while `depth` is 31 sets `stk_ovf`, which stays set until reset. `depth` stays at 31 and the stored entries are unchanged.
- R8: A return accepted while `depth` is 0 sets `stk_unf`, which stays set until reset. It also gives `pc_next` = 0 with `pc_load` = 1, and `depth` stays 0.
- R9: After reset, `depth`, `stk_ovf`, `stk_unf`, `pc_load`, `ret_slot` and `restore_en` are 0, and the saved copies are 0.
- R10: When a return and a call are presented in the same cycle, the return is taken and the call is discarded. No push happens and `pc_next` comes from the stack.
- R11: Popped addresses come out in the reverse of their push order across the full depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | `instr_word` holds an instruction to decode this cycle |
| instr_word | input | 16 | Instruction word from the decode stage |
| call_req | input | 1 | A call instruction is executing this cycle |
| call_fast | input | 1 | The current call also captures the saved register copies |
| call_target | input | 21 | Jump address of the call |
| pc_in | input | 21 | Address of the instruction currently executing |
| shadow_load | input | 1 | Capture strobe from the interrupt logic |
| w_in | input | 8 | Live working register value |
| status_in | input | 8 | Live status register value |
| bsr_in | input | 4 | Live bank select register value |
| pc_load | output | 1 | Load `pc_next` into the program counter |
| pc_next | output | 21 | New program counter value |
| ret_slot | output | 1 | Second, no-operation cycle of a return |
| restore_en | output | 1 | Write the saved copies back into the live registers |
| w_out | output | 8 | Saved working register copy |
| status_out | output | 8 | Saved status register copy |
| bsr_out | output | 4 | Saved bank select register copy |
| depth | output | 5 | Number of stored return addresses |
| stk_ovf | output | 1 | Sticky overflow flag |
| stk_unf | output | 1 | Sticky underflow flag |

## Verification
Returns are tried with both values of the restore bit after a plain shadow load and after a fast call. This separates the restore strobe from the pop itself and shows which capture path filled the copies. Near-miss words differ from the return opcode in the restore position's neighbours, in the upper byte and in the valid strobe, so a decoder that masks too many bits is caught. A return or call placed in the dead slot, and a return placed alongside a call, show whether the slot blocking and the return-over-call priority are real. A full push-to-overflow and pop-to-empty run, ending in a pop from an empty stack, checks the reverse ordering, that the 32nd push is discarded, and the zero result on underflow.

// File: rtl/retstk_pkg.sv
package retstk_pkg;

   // Upper fifteen bits of the return opcode; bit 0 is the restore select.
   localparam logic [14:0] RET_OPC_HI = 15'h0009;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_RET  = 2'd1,
      OP_CALL = 2'd2
   } stk_op_e;

   function automatic logic is_ret_word(input logic [15:0] word);
      return word[15:1] == RET_OPC_HI;
   endfunction

endpackage

// File: rtl/retstk_decode.sv
module retstk_decode
   import retstk_pkg::*;
(
   input  logic        instr_valid,
   input  logic [15:0] instr_word,
   input  logic        call_req,
   input  logic        slot_busy,
   output stk_op_e     op,
   output logic        restore_sel
);

   logic ret_seen;

   assign ret_seen = instr_valid && is_ret_word(instr_word);

   always_comb begin
      op          = OP_IDLE;
      restore_sel = 1'b0;
      if (!slot_busy) begin
         if (ret_seen) begin
            op          = OP_RET;
            restore_sel = instr_word[0];
         end else if (call_req) begin
            op = OP_CALL;
         end
      end
   end

endmodule

// File: rtl/retstk_lifo.sv
module retstk_lifo #(
   parameter int AW    = 21,
   parameter int DEPTH = 31,
   localparam int PW   = $clog2(DEPTH + 1),
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_data,
   input  logic          pop,
   output logic [AW-1:0] pop_q,
   output logic [PW-1:0] depth,
   output logic          ovf,
   output logic          unf
);

   logic [AW-1:0] mem [DEPTH];
   logic [PW-1:0] cnt_q;
   logic [PW-1:0] top_idx;
   logic          full;
   logic          empty;
   logic          wr_ok;

   assign full    = cnt_q == PW'(DEPTH);
   assign empty   = cnt_q == '0;
   assign top_idx = cnt_q - PW'(1);
   assign wr_ok   = push && !pop && !full;
   assign depth   = cnt_q;

   always_ff @(posedge clk) begin
      if (wr_ok) begin
         mem[cnt_q[IW-1:0]] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pop_q <= '0;
         ovf   <= 1'b0;
         unf   <= 1'b0;
      end else if (pop) begin
         if (empty) begin
            unf   <= 1'b1;
            pop_q <= '0;
         end else begin
            pop_q <= mem[top_idx[IW-1:0]];
            cnt_q <= top_idx;
         end
      end else if (push) begin
         if (full) begin
            ovf <= 1'b1;
         end else begin
            cnt_q <= cnt_q + PW'(1);
         end
      end
   end

   // R7: a push into a full stack raises the flag and keeps the count
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && full) |=> (ovf && depth == PW'(DEPTH)));

   // R8: a pop from an empty stack yields zero and raises the flag
   assert_empty_pop_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty) |=> (unf && pop_q == '0 && depth == '0));

   // R11: every pop of a non-empty stack removes exactly one entry
   assert_pop_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !empty) |=> (depth == $past(depth) - PW'(1)));

endmodule

// File: rtl/retstk_shadow.sv
module retstk_shadow #(
   parameter int DW = 8,
   parameter int BW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] w_in,
   input  logic [DW-1:0] st_in,
   input  logic [BW-1:0] bsr_in,
   output logic [DW-1:0] w_q,
   output logic [DW-1:0] st_q,
   output logic [BW-1:0] bsr_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_q   <= '0;
         st_q  <= '0;
         bsr_q <= '0;
      end else if (load) begin
         w_q   <= w_in;
         st_q  <= st_in;
         bsr_q <= bsr_in;
      end
   end

   // R6: copies hold unless a capture strobe was present
   assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(w_q) && $stable(st_q) && $stable(bsr_q)));

   // R6: a capture takes the live values of that edge
   assert_shadow_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (w_q == $past(w_in) && st_q == $past(st_in) && bsr_q == $past(bsr_in)));

endmodule

// File: rtl/retstk_unit.sv
module retstk_unit
   import retstk_pkg::*;
#(
   parameter int AW    = 21,
   parameter int DEPTH = 31,
   parameter int DW    = 8,
   parameter int BW    = 4,
   localparam int PW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          instr_valid,
   input  logic [15:0]   instr_word,
   input  logic          call_req,
   input  logic          call_fast,
   input  logic [AW-1:0] call_target,
   input  logic [AW-1:0] pc_in,
   input  logic          shadow_load,
   input  logic [DW-1:0] w_in,
   input  logic [DW-1:0] status_in,
   input  logic [BW-1:0] bsr_in,
   output logic          pc_load,
   output logic [AW-1:0] pc_next,
   output logic          ret_slot,
   output logic          restore_en,
   output logic [DW-1:0] w_out,
   output logic [DW-1:0] status_out,
   output logic [BW-1:0] bsr_out,
   output logic [PW-1:0] depth,
   output logic          stk_ovf,
   output logic          stk_unf
);

   // elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("retstk_unit: DEPTH must be at least 2");
   end
   if (AW < 2) begin : g_bad_aw
      $error("retstk_unit: AW must be at least 2");
   end
   if (DW < 1 || BW < 1) begin : g_bad_regw
      $error("retstk_unit: register widths must be positive");
   end

   stk_op_e       op;
   logic          restore_sel;
   logic          slot_q;
   logic          restore_q;
   logic          call_q;
   logic [AW-1:0] tgt_q;
   logic [AW-1:0] pop_q;
   logic [AW-1:0] link_addr;
   logic          cap_now;

   retstk_decode u_dec (
      .instr_valid (instr_valid),
      .instr_word  (instr_word),
      .call_req    (call_req),
      .slot_busy   (slot_q),
      .op          (op),
      .restore_sel (restore_sel)
   );

   assign link_addr = pc_in + AW'(2);

   retstk_lifo #(.AW(AW), .DEPTH(DEPTH)) u_lifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (op == OP_CALL),
      .push_data (link_addr),
      .pop       (op == OP_RET),
      .pop_q     (pop_q),
      .depth     (depth),
      .ovf       (stk_ovf),
      .unf       (stk_unf)
   );

   assign cap_now = shadow_load || (op == OP_CALL && call_fast);

   retstk_shadow #(.DW(DW), .BW(BW)) u_shadow (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (cap_now),
      .w_in   (w_in),
      .st_in  (status_in),
      .bsr_in (bsr_in),
      .w_q    (w_out),
      .st_q   (status_out),
      .bsr_q  (bsr_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q    <= 1'b0;
         restore_q <= 1'b0;
         call_q    <= 1'b0;
         tgt_q     <= '0;
      end else begin
         slot_q    <= op == OP_RET;
         restore_q <= op == OP_RET && restore_sel;
         call_q    <= op == OP_CALL;
         if (op == OP_CALL) begin
            tgt_q <= call_target;
         end
      end
   end

   assign pc_load    = slot_q || call_q;
   assign pc_next    = slot_q ? pop_q : tgt_q;
   assign ret_slot   = slot_q;
   assign restore_en = restore_q;

   // R2: an accepted return loads the program counter one cycle later
   assert_ret_loads_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && is_ret_word(instr_word) && !ret_slot) |=> (pc_load && ret_slot));

   // R3: the restore strobe only appears in the return's second cycle
   assert_restore_in_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      restore_en |-> ret_slot);

   // R4: nothing presented during the dead slot produces a load
   assert_slot_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ret_slot |=> !pc_load);

   // R10: a return beside a call keeps the stack from growing
   assert_ret_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && is_ret_word(instr_word) && call_req && !ret_slot)
         |=> (ret_slot && depth <= $past(depth)));

endmodule

// File: tb/retstk_unit_tb_top.sv
module retstk_unit_tb_top;

   localparam int AW = 21;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          instr_valid = 1'b0;
   logic [15:0]   instr_word = '0;
   logic          call_req = 1'b0;
   logic          call_fast = 1'b0;
   logic [AW-1:0] call_target = '0;
   logic [AW-1:0] pc_in = '0;
   logic          shadow_load = 1'b0;
   logic [7:0]    w_in = '0;
   logic [7:0]    status_in = '0;
   logic [3:0]    bsr_in = '0;
   logic          pc_load;
   logic [AW-1:0] pc_next;
   logic          ret_slot;
   logic          restore_en;
   logic [7:0]    w_out;
   logic [7:0]    status_out;
   logic [3:0]    bsr_out;
   logic [4:0]    depth;
   logic          stk_ovf;
   logic          stk_unf;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   retstk_unit dut_i (
      .clk (clk), .rst_n (rst_n),
      .instr_valid (instr_valid), .instr_word (instr_word),
      .call_req (call_req), .call_fast (call_fast), .call_target (call_target),
      .pc_in (pc_in), .shadow_load (shadow_load),
      .w_in (w_in), .status_in (status_in), .bsr_in (bsr_in),
      .pc_load (pc_load), .pc_next (pc_next), .ret_slot (ret_slot),
      .restore_en (restore_en), .w_out (w_out), .status_out (status_out),
      .bsr_out (bsr_out), .depth (depth), .stk_ovf (stk_ovf), .stk_unf (stk_unf)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic do_call(input logic [AW-1:0] pc, input logic [AW-1:0] tgt, input bit fast);
      call_req = 1'b1; pc_in = pc; call_target = tgt; call_fast = fast;
      @(negedge clk);
      call_req = 1'b0; call_fast = 1'b0;
   endtask

   task automatic do_ret(input bit s);
      instr_valid = 1'b1; instr_word = {15'h0009, s};
      @(negedge clk);
      instr_valid = 1'b0; instr_word = '0;
   endtask

   task automatic t_reset();
      chk("R9 depth", 32'(depth), 0);
      chk("R9 flags", {30'd0, stk_ovf, stk_unf}, 0);
      chk("R9 strobes", {29'd0, pc_load, ret_slot, restore_en}, 0);
      chk("R9 shadows", {12'd0, w_out, status_out, bsr_out}, 0);
   endtask

   task automatic t_call_ret();
      do_call(21'h100, 21'h2000, 1'b0);
      chk("R5 call load", 32'(pc_load), 1);
      chk("R5 call target", 32'(pc_next), 32'h2000);
      chk("R5 depth up", 32'(depth), 1);
      idle();
      do_ret(1'b0);
      chk("R2 pc_load", 32'(pc_load), 1);
      chk("R2 pc_next", 32'(pc_next), 32'h102);
      chk("R2 depth down", 32'(depth), 0);
      chk("R4 slot flag", 32'(ret_slot), 1);
      chk("R3 no restore s=0", 32'(restore_en), 0);
      idle();
   endtask

   task automatic t_shadow();
      w_in = 8'hA5; status_in = 8'h3C; bsr_in = 4'h9; shadow_load = 1'b1;
      @(negedge clk);
      shadow_load = 1'b0; w_in = 8'h11; status_in = 8'h22; bsr_in = 4'h3;
      chk("R6 capture", {12'd0, w_out, status_out, bsr_out}, {12'd0, 8'hA5, 8'h3C, 4'h9});
      do_call(21'h40, 21'h800, 1'b0);
      chk("R6 plain call keeps", 32'(w_out), 32'hA5);
      idle();
      do_ret(1'b1);
      chk("R3 restore s=1", 32'(restore_en), 1);
      chk("R3 restore values", {12'd0, w_out, status_out, bsr_out}, {12'd0, 8'hA5, 8'h3C, 4'h9});
      chk("R2 pc after s=1", 32'(pc_next), 32'h42);
      idle();
      w_in = 8'h5A; status_in = 8'hC3; bsr_in = 4'h6;
      do_call(21'h80, 21'h900, 1'b1);
      chk("R6 fast call capture", {12'd0, w_out, status_out, bsr_out}, {12'd0, 8'h5A, 8'hC3, 4'h6});
      idle();
      do_ret(1'b1);
      chk("R3 restore after fast", {12'd0, w_out, 3'd0, restore_en}, {12'd0, 8'h5A, 4'h1});
      idle();
   endtask

   task automatic t_reject();
      logic [15:0] bad [4] = '{16'h0011, 16'h0014, 16'h8012, 16'h0112};
      do_call(21'h60, 21'h700, 1'b0);
      idle();
      foreach (bad[i]) begin
         instr_valid = 1'b1; instr_word = bad[i];
         @(negedge clk);
         instr_valid = 1'b0;
         chk("R1 reject word", {15'd0, bad[i], pc_load}, {15'd0, bad[i], 1'b0});
      end
      instr_valid = 1'b0; instr_word = 16'h0013;
      @(negedge clk);
      chk("R1 no valid", {26'd0, pc_load, depth}, 32'd1);
      do_ret(1'b0);
      chk("R1 accept 0012", 32'(pc_next), 32'h62);
      idle();
   endtask

   task automatic t_slot();
      do_call(21'h10, 21'h500, 1'b0);
      do_call(21'h20, 21'h600, 1'b0);
      do_ret(1'b0);
      chk("R2 first pop", 32'(pc_next), 32'h22);
      do_ret(1'b1);
      chk("R4 ret in slot ignored", {26'd0, pc_load, depth}, 32'd1);
      chk("R4 no restore in slot", 32'(restore_en), 0);
      do_ret(1'b0);
      chk("R2 second pop", 32'(pc_next), 32'h12);
      do_call(21'h30, 21'h400, 1'b0);
      chk("R4 call in slot ignored", {26'd0, pc_load, depth}, 32'd0);
   endtask

   task automatic t_priority();
      do_call(21'h300, 21'h1000, 1'b0);
      idle();
      instr_valid = 1'b1; instr_word = 16'h0012;
      call_req = 1'b1; pc_in = 21'h500; call_target = 21'h900;
      @(negedge clk);
      instr_valid = 1'b0; call_req = 1'b0;
      chk("R10 return wins", 32'(pc_next), 32'h302);
      chk("R10 no push", {26'd0, ret_slot, depth}, 32'h20);
      idle();
   endtask

   task automatic t_fill();
      for (int i = 0; i < 31; i++) begin
         do_call(AW'(i * 8), 21'h1234, 1'b0);
      end
      chk("R7 full depth", {26'd0, stk_ovf, depth}, 32'd31);
      do_call(21'h1FFF0, 21'h1234, 1'b0);
      chk("R7 overflow flag", {26'd0, stk_ovf, depth}, 32'h3F);
      idle();
      for (int k = 0; k < 31; k++) begin
         do_ret(1'b0);
         chk("R11 lifo order", 32'(pc_next), 32'((30 - k) * 8 + 2));
         idle();
      end
      chk("R11 emptied", 32'(depth), 0);
      chk("R7 sticky", 32'(stk_ovf), 1);
   endtask

   task automatic t_underflow();
      chk("R8 before", 32'(stk_unf), 0);
      do_ret(1'b0);
      chk("R8 zero pc", {10'd0, pc_load, pc_next}, {10'd0, 1'b1, 21'd0});
      chk("R8 flag and depth", {26'd0, stk_unf, depth}, 32'h20);
      idle();
      idle();
      chk("R8 sticky", 32'(stk_unf), 1);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_call_ret();
      t_shadow();
      t_reject();
      t_slot();
      t_priority();
      t_fill();
      t_underflow();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule